// File: doc/BRIEF.md
# Dual-Port RAM with Collision Tracking

This block is a synchronous RAM with two independent access ports, A and B, on a single clock. Each port can read or write any word in any cycle, and each has its own enable, write enable, address and write data. Read data comes back one cycle after the access, together with a valid flag and a collision flag for that port.

When both ports touch the same word in the same cycle and at least one of them writes, the block flags a collision on both ports. A port that reads a word while the other port writes it receives data marked invalid, and the write still lands. When both ports write the same word in one cycle, the stored value is undefined. The block keeps one poison bit per word to mark this case. Any later read of that word reports invalid until a single port writes the word again.

Port A returns the old word while it writes (read-first). Port B returns the word it writes (write-first). Each port's mode is a parameter. The mode shapes only that port's own read output and never hides a collision. Each port classifies its access in a cycle as one of three access states: `OP_IDLE` (enable low), `OP_READ` (enable high, write enable low) or `OP_WRITE` (both high). A port takes a new state every cycle with no restriction between states, and the registered copy of that state selects what the port returns one cycle later.

Top module: `dpr_collide_ram`

## Requirements
- R1: A read issued in cycle N returns, after the clock edge that ends cycle N, the last value written to that address, with rvalid=1 and coll=0.
- R2: A port with its enable low performs no access. One cycle later its rvalid=0 and coll=0. Its write enable, address and data have no effect on memory. The other port sees no collision from it.
- R3: Port A (read-first) writing a word returns the previous contents of that word one cycle later, with rvalid=1 when the word is not poisoned and no cross-port write hits it.
- R4: Port B (write-first) writing a word returns its own write data one cycle later with rvalid=1, unless port A writes the same word in the same cycle.
- R5: coll rises on both ports one cycle after a cycle in which both ports are enabled on equal addresses and at least one port writes. Different addresses, or two reads, give coll=0 on both ports.
- R6: In a write-versus-read collision the write is stored. The reading port returns rvalid=0.
- R7: The invalid result of R6 lasts one cycle only. A fresh read of the same word in the next cycle returns the newly written value with rvalid=1.
- R8: When both ports write the same address in one cycle, both ports return coll=1 and rvalid=0 one cycle later, and the word becomes poisoned. Every later read of it returns rvalid=0. Other words are unaffected.
- R9: A write to a poisoned word by one port alone clears its poison. Later reads return the new value with rvalid=1.
- R10: The write mode never masks a collision. If a read-first or write-first port writes while the other port reads the same word, the reader still gets rvalid=0 and both ports still report coll=1.
- R11: After reset, rvalid=0 and coll=0 on both ports, and no word is poisoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset of flags and poison bits |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W (10) | Port A word address |
| a_wdata | input | DATA_W (16) | Port A write data |
| a_rdata | output | DATA_W (16) | Port A registered read data |
| a_rvalid | output | 1 | Port A read data trustworthy |
| a_coll | output | 1 | Port A took part in a same-address conflict |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W (10) | Port B word address |
| b_wdata | input | DATA_W (16) | Port B write data |
| b_rdata | output | DATA_W (16) | Port B registered read data |
| b_rvalid | output | 1 | Port B read data trustworthy |
| b_coll | output | 1 | Port B took part in a same-address conflict |

## Verification
The hardest condition to reach is a poisoned word that a single port then rewrites in read-first mode. The writing port must report invalid, because the old word it returns is undefined, and the next read must then come back valid. To build this, the bench first issues a same-cycle double write to one address. It confirms the poison with reads from both ports. It then rewrites the word from port A alone and reads it back. A second poisoned address is repaired from write-first port B instead. A neighbouring word is read at the same time to show that the poison stays confined to its own address.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

    typedef enum logic {
        WM_READ_FIRST  = 1'b0,
        WM_WRITE_FIRST = 1'b1
    } wmode_e;

    localparam int NPORT = 2;

    function automatic port_op_e classify(input logic en, input logic we);
        if (!en)
            return OP_IDLE;
        else if (we)
            return OP_WRITE;
        else
            return OP_READ;
    endfunction

endpackage

// File: rtl/dpr_pair_cmp.sv
module dpr_pair_cmp
    import dpr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic [NPORT-1:0]             en,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    output port_op_e                     op     [NPORT],
    output logic [NPORT-1:0]             coll,
    output logic [NPORT-1:0]             xwrite,
    output logic                         dual_wr
);

    logic same_word;

    assign same_word = en[0] && en[1] && (addr[0] == addr[1]);
    assign dual_wr   = same_word && we[0] && we[1];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign op[p]     = classify(en[p], we[p]);
        assign coll[p]   = same_word && (we[0] || we[1]);
        assign xwrite[p] = same_word && we[NPORT-1-p];
    end

endmodule

// File: rtl/dpr_store.sv
module dpr_store
    import dpr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NPORT-1:0]             en,
    input  logic [NPORT-1:0]             we,
    input  logic [NPORT-1:0][ADDR_W-1:0] addr,
    input  logic [NPORT-1:0][DATA_W-1:0] wdata,
    input  logic                         dual_wr,
    output logic [NPORT-1:0][DATA_W-1:0] old_q,
    output logic [NPORT-1:0]             psn_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  psn;

    // storage array, no reset
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (en[p] && we[p])
                mem[addr[p]] <= wdata[p];
        end
    end

    // poison: set by a same-word double write, cleared by a lone write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psn <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (en[p] && we[p])
                    psn[addr[p]] <= dual_wr;
            end
        end
    end

    // registered view of the word before this cycle's writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            psn_q <= '0;
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (en[p]) begin
                    old_q[p] <= mem[addr[p]];
                    psn_q[p] <= psn[addr[p]];
                end
            end
        end
    end

endmodule

// File: rtl/dpr_port_stage.sv
module dpr_port_stage
    import dpr_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter wmode_e MODE   = WM_READ_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_op_e          op,
    input  logic              coll,
    input  logic              xwrite,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] old_q,
    input  logic              psn_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              rcoll
);

    port_op_e          op_q;
    logic              coll_q;
    logic              xw_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] wr_data;
    logic              wr_ok;

    // access-state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            coll_q <= 1'b0;
            xw_q   <= 1'b0;
            wd_q   <= '0;
        end else begin
            op_q   <= op;
            coll_q <= coll;
            xw_q   <= xwrite;
            wd_q   <= wdata;
        end
    end

    // write-mode variant chosen by parameter
    if (MODE == WM_WRITE_FIRST) begin : g_wf
        always_comb begin
            wr_data = wd_q;
            wr_ok   = !xw_q;
        end
    end else begin : g_rf
        always_comb begin
            wr_data = old_q;
            wr_ok   = !xw_q && !psn_q;
        end
    end

    // outputs per registered access state
    always_comb begin
        rdata  = old_q;
        rvalid = 1'b0;
        unique case (op_q)
            OP_IDLE: begin
                rdata  = old_q;
                rvalid = 1'b0;
            end
            OP_READ: begin
                rdata  = old_q;
                rvalid = !xw_q && !psn_q;
            end
            OP_WRITE: begin
                rdata  = wr_data;
                rvalid = wr_ok;
            end
            default: begin
                rdata  = old_q;
                rvalid = 1'b0;
            end
        endcase
    end

    assign rcoll = coll_q;

endmodule

// File: rtl/dpr_collide_ram.sv
module dpr_collide_ram
    import dpr_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     ADDR_W = 10,
    parameter wmode_e A_MODE = WM_READ_FIRST,
    parameter wmode_e B_MODE = WM_WRITE_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    output logic              a_coll,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid,
    output logic              b_coll
);

    logic [NPORT-1:0]             en, we, coll, xwrite, psn_q;
    logic [NPORT-1:0][ADDR_W-1:0] addr;
    logic [NPORT-1:0][DATA_W-1:0] wdata, old_q, rdata;
    logic [NPORT-1:0]             rvalid, rcoll;
    port_op_e                     op [NPORT];
    logic                         dual_wr;

    assign en    = {b_en, a_en};
    assign we    = {b_we, a_we};
    assign addr  = {b_addr, a_addr};
    assign wdata = {b_wdata, a_wdata};

    dpr_pair_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .en(en), .we(we), .addr(addr),
        .op(op), .coll(coll), .xwrite(xwrite), .dual_wr(dual_wr)
    );

    dpr_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
        .wdata(wdata), .dual_wr(dual_wr), .old_q(old_q), .psn_q(psn_q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_stage
        localparam wmode_e PMODE = (p == 0) ? A_MODE : B_MODE;
        dpr_port_stage #(.DATA_W(DATA_W), .MODE(PMODE)) u_stage (
            .clk(clk), .rst_n(rst_n), .op(op[p]), .coll(coll[p]),
            .xwrite(xwrite[p]), .wdata(wdata[p]), .old_q(old_q[p]),
            .psn_q(psn_q[p]), .rdata(rdata[p]), .rvalid(rvalid[p]),
            .rcoll(rcoll[p])
        );
    end

    assign a_rdata  = rdata[0];
    assign a_rvalid = rvalid[0];
    assign a_coll   = rcoll[0];
    assign b_rdata  = rdata[1];
    assign b_rvalid = rvalid[1];
    assign b_coll   = rcoll[1];

endmodule

// File: rtl/dpr_collide_ram_chk.sv
module dpr_collide_ram_chk
    import dpr_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter int     ADDR_W = 10,
    parameter wmode_e A_MODE = WM_READ_FIRST,
    parameter wmode_e B_MODE = WM_WRITE_FIRST
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_en,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_addr,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_rvalid,
    input logic              a_coll,
    input logic              b_en,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr,
    input logic [DATA_W-1:0] b_wdata,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_rvalid,
    input logic              b_coll
);

    assert_dual_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && b_en && b_we && a_addr == b_addr)
        |=> (a_coll && b_coll && !a_rvalid && !b_rvalid));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> (!a_rvalid && !a_coll && !b_coll));

    assert_write_vs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && !a_we && b_en && b_we && a_addr == b_addr)
        |=> (a_coll && b_coll && !a_rvalid));

    assert_no_coll_diff_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && a_addr != b_addr) |=> (!a_coll && !b_coll));

    assert_write_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (B_MODE == WM_WRITE_FIRST && b_en && b_we
         && !(a_en && a_we && a_addr == b_addr))
        |=> (b_rvalid && b_rdata == $past(b_wdata)));

endmodule

bind dpr_collide_ram dpr_collide_ram_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_MODE(A_MODE), .B_MODE(B_MODE)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_coll(a_coll),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_coll(b_coll)
);

// File: tb/test_dpr_collide_ram.sv
module test_dpr_collide_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [9:0]  a_addr = '0, b_addr = '0;
    logic [15:0] a_wdata = '0, b_wdata = '0;
    logic [15:0] a_rdata, b_rdata;
    logic        a_rvalid, a_coll, b_rvalid, b_coll;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    dpr_collide_ram i_dpr_collide_ram (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_rvalid(a_rvalid), .a_coll(a_coll),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_rvalid(b_rvalid), .b_coll(b_coll)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive one cycle from a falling edge; outputs are sampled at the next one
    task automatic cyc(input logic ae, input logic awe, input logic [9:0] aa, input logic [15:0] ad,
                       input logic be, input logic bwe, input logic [9:0] ba, input logic [15:0] bd);
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        @(negedge clk);
        a_en = 0; a_we = 0; b_en = 0; b_we = 0;
    endtask

    task automatic t_reset();
        chk("R11 a_rvalid", a_rvalid, 0);
        chk("R11 a_coll", a_coll, 0);
        chk("R11 b_rvalid", b_rvalid, 0);
        chk("R11 b_coll", b_coll, 0);
    endtask

    task automatic t_basic();
        cyc(1, 1, 10'd5, 16'h1234, 1, 1, 10'd10, 16'hBEEF);
        cyc(1, 0, 10'd10, 0, 1, 0, 10'd5, 0);
        chk("R1 a_rdata", a_rdata, 16'hBEEF);
        chk("R1 a_rvalid", a_rvalid, 1);
        chk("R1 b_rdata", b_rdata, 16'h1234);
        chk("R1 b_rvalid", b_rvalid, 1);
        chk("R5 diff addr a_coll", a_coll, 0);
        cyc(1, 1, 10'd0, 16'h0A0A, 1, 1, 10'd1023, 16'hF0F0);
        chk("R5 diff write a_coll", a_coll, 0);
        chk("R5 diff write b_coll", b_coll, 0);
        cyc(1, 0, 10'd1023, 0, 1, 0, 10'd0, 0);
        chk("R1 top addr", a_rdata, 16'hF0F0);
        chk("R1 addr zero", b_rdata, 16'h0A0A);
    endtask

    task automatic t_idle();
        cyc(0, 1, 10'd5, 16'hDEAD, 1, 0, 10'd5, 0);
        chk("R2 a_rvalid", a_rvalid, 0);
        chk("R2 a_coll", a_coll, 0);
        chk("R2 b_coll", b_coll, 0);
        chk("R2 b_rvalid", b_rvalid, 1);
        chk("R2 b_rdata", b_rdata, 16'h1234);
        cyc(1, 0, 10'd5, 0, 0, 0, 0, 0);
        chk("R2 memory untouched", a_rdata, 16'h1234);
    endtask

    task automatic t_modes();
        cyc(1, 1, 10'd5, 16'h5555, 0, 0, 0, 0);
        chk("R3 old word", a_rdata, 16'h1234);
        chk("R3 a_rvalid", a_rvalid, 1);
        cyc(1, 0, 10'd5, 0, 1, 1, 10'd7, 16'h7777);
        chk("R3 write landed", a_rdata, 16'h5555);
        chk("R4 new word", b_rdata, 16'h7777);
        chk("R4 b_rvalid", b_rvalid, 1);
    endtask

    task automatic t_cross();
        cyc(1, 1, 10'd20, 16'h2020, 1, 1, 10'd30, 16'h3030);
        // B write-first writes while A reads
        cyc(1, 0, 10'd20, 0, 1, 1, 10'd20, 16'h2121);
        chk("R6 a_rvalid", a_rvalid, 0);
        chk("R5 a_coll", a_coll, 1);
        chk("R10 b_coll", b_coll, 1);
        chk("R10 b_rvalid", b_rvalid, 1);
        chk("R10 b_rdata", b_rdata, 16'h2121);
        cyc(1, 0, 10'd20, 0, 0, 0, 0, 0);
        chk("R7 a_rvalid", a_rvalid, 1);
        chk("R7 a_rdata", a_rdata, 16'h2121);
        chk("R7 a_coll", a_coll, 0);
        // A read-first writes while B reads
        cyc(1, 1, 10'd30, 16'h3131, 1, 0, 10'd30, 0);
        chk("R10 reader b_rvalid", b_rvalid, 0);
        chk("R10 b_coll", b_coll, 1);
        chk("R10 a_coll", a_coll, 1);
        chk("R3 a_rdata old", a_rdata, 16'h3030);
        cyc(0, 0, 0, 0, 1, 0, 10'd30, 0);
        chk("R6 write landed", b_rdata, 16'h3131);
        chk("R7 b_rvalid", b_rvalid, 1);
        cyc(1, 0, 10'd20, 0, 1, 0, 10'd20, 0);
        chk("R5 two reads a_coll", a_coll, 0);
        chk("R5 two reads b_coll", b_coll, 0);
        chk("R5 two reads valid", {a_rvalid, b_rvalid}, 2'b11);
    endtask

    task automatic t_poison();
        cyc(1, 1, 10'd40, 16'h4444, 1, 1, 10'd40, 16'h4545);
        chk("R8 a_coll", a_coll, 1);
        chk("R8 b_coll", b_coll, 1);
        chk("R8 a_rvalid", a_rvalid, 0);
        chk("R8 b_rvalid", b_rvalid, 0);
        cyc(1, 0, 10'd40, 0, 1, 0, 10'd20, 0);
        chk("R8 poisoned read", a_rvalid, 0);
        chk("R8 poisoned read coll", a_coll, 0);
        chk("R8 neighbour valid", b_rvalid, 1);
        chk("R8 neighbour data", b_rdata, 16'h2121);
        cyc(0, 0, 0, 0, 1, 0, 10'd40, 0);
        chk("R8 poisoned read B", b_rvalid, 0);
        cyc(1, 1, 10'd40, 16'h4646, 0, 0, 0, 0);
        chk("R9 rf write of poisoned word", a_rvalid, 0);
        cyc(0, 0, 0, 0, 1, 0, 10'd40, 0);
        chk("R9 cleared valid", b_rvalid, 1);
        chk("R9 cleared data", b_rdata, 16'h4646);
        cyc(1, 1, 10'd41, 16'h1111, 1, 1, 10'd41, 16'h2222);
        cyc(0, 0, 0, 0, 1, 1, 10'd41, 16'h4141);
        chk("R9 wf repair valid", b_rvalid, 1);
        chk("R9 wf repair data", b_rdata, 16'h4141);
        cyc(1, 0, 10'd41, 0, 0, 0, 0, 0);
        chk("R9 read after repair", a_rdata, 16'h4141);
        chk("R9 read after repair valid", a_rvalid, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_idle();
        t_modes();
        t_cross();
        t_poison();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule